// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block sits beside one PCIe controller. It turns the 16-bit requester ID of an inbound request (bus, device and function) into a stream ID that downstream address-translation logic can use. Software fills a small associative table through a 32-bit register port. Each table slot has two words. The first word holds an ID pattern and a per-bit don't-care mask. The second word holds an enable flag and the stream ID to return.

On the lookup side, a requester ID and a valid strobe go in. One clock later the block returns a hit flag and the stream ID of the matching slot. When more than one enabled slot matches, the slot with the lowest index is chosen. When no enabled slot matches, the hit flag is low and the stream ID is zero. Every slot is compared in parallel in a single cycle.

Top module: `rid_stream_lut`

## Requirements
- R1: After a synchronous active-low reset, every slot is disabled and all slot fields read back as zero. `res_valid`, `res_hit` and `res_sid` are zero.
- R2: The ID/mask word of slot n is at byte address 0x800 + 8·n. It holds the requester ID pattern in bits [31:16] and the mask in bits [15:0], and it reads back exactly as written.
- R3: The enable/stream word of slot n is at byte address 0x804 + 8·n. Bit 31 is the enable and bits [15:0] are the stream ID. Bits [30:16] read as zero whatever was written to them.
- R4: A slot matches when each requester-ID bit whose mask bit is 0 equals the pattern bit. Requester-ID bits whose mask bit is 1 are ignored.
- R5: A slot whose enable bit is 0 never produces a hit, even when its pattern matches.
- R6: When several enabled slots match, the stream ID of the lowest-index slot is returned.
- R7: On a lookup that matches no enabled slot, `res_hit` is 0 and `res_sid` is zero.
- R8: The result of a lookup presented at a clock edge appears after that edge. `res_valid` is a one-cycle-delayed copy of `lk_valid`. While `res_valid` is 0, `res_hit` is 0.
- R9: A lookup presented in the same cycle as a register write sees the table as it was before the write. The next lookup sees the new contents.
- R10: Word-aligned addresses outside 0x800 to 0x800 + 8·32 − 1 are ignored on write and read back as zero.
- R11: Read data for `reg_addr` appears on `reg_rdata` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address within the table block |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered readback of `reg_addr` |
| lk_valid | input | 1 | Lookup request strobe |
| lk_rid | input | 16 | Requester ID to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | An enabled slot matched |
| res_sid | output | 16 | Stream ID of the winning slot, zero on a miss |

## Verification
A register write and a lookup can happen in the same clock. The write can change exactly the slot that the lookup would hit. The bench triggers this by enabling a slot that was disabled, while in the same cycle looking up an ID that matches that slot. The lookup must report a miss. A second lookup right after it must return the newly enabled stream ID. A companion case disables the lowest-index winner and checks that the next slot in priority takes over on the following lookup.

// File: rtl/rid_lut_pkg.sv
// Package: shared widths and the table-slot record.
// Assumes 16-bit requester IDs and 16-bit stream IDs.
package rid_lut_pkg;
    localparam int RID_W = 16;
    localparam int SID_W = 16;

    typedef struct packed {
        logic             en;
        logic [RID_W-1:0] pattern;
        logic [RID_W-1:0] dc_mask;
        logic [SID_W-1:0] sid;
    } slot_t;
endpackage

// File: rtl/rid_lut_regs.sv
// Slot storage with register write decode and registered readback.
// Assumes word-aligned byte addresses. Each slot uses two words:
// ID/mask at +0 and enable/stream at +4.
module rid_lut_regs
    import rid_lut_pkg::*;
#(
    parameter int          NUM_SLOTS = 32,
    parameter logic [11:0] TBL_BASE  = 12'h800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output slot_t       slots [NUM_SLOTS]
);
    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam int SPAN  = NUM_SLOTS * 8;

    logic [11:0]      off;
    logic             in_tbl;
    logic             lo_word;
    logic [IDX_W-1:0] idx;

    // Decode the address into a slot index and a word select.
    always_comb begin
        off     = reg_addr - TBL_BASE;
        in_tbl  = (reg_addr >= TBL_BASE) && (32'(off) < SPAN) && (reg_addr[1:0] == 2'b00);
        lo_word = off[2];
        idx     = off[IDX_W+2:3];
    end

    // Store slot fields; reserved bits of the lower word are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) slots[i] <= '0;
        end else if (reg_we && in_tbl) begin
            if (lo_word) begin
                slots[idx].en  <= reg_wdata[31];
                slots[idx].sid <= reg_wdata[SID_W-1:0];
            end else begin
                slots[idx].pattern <= reg_wdata[31:16];
                slots[idx].dc_mask <= reg_wdata[15:0];
            end
        end
    end

    // Register the readback word for the presented address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (!in_tbl)
            reg_rdata <= '0;
        else if (lo_word)
            reg_rdata <= {slots[idx].en, 15'b0, slots[idx].sid};
        else
            reg_rdata <= {slots[idx].pattern, slots[idx].dc_mask};
    end

    // A write to an ID/mask word lands in that slot.
    assert_pattern_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && in_tbl && !lo_word) |=>
            slots[$past(idx)].pattern == $past(reg_wdata[31:16]));

    // A write to an enable/stream word lands in that slot.
    assert_enable_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && in_tbl && lo_word) |=>
            slots[$past(idx)].en == $past(reg_wdata[31]));

    // Reads outside the table return zero.
    assert_outside_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tbl |=> reg_rdata == 32'h0);
endmodule

// File: rtl/rid_lut_match.sv
// Parallel masked compare of one requester ID against every slot.
// Assumes a mask bit of 1 marks a don't-care ID bit.
// Disabled slots never match.
module rid_lut_match
    import rid_lut_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  slot_t            slots [NUM_SLOTS],
    input  logic [RID_W-1:0] rid,
    output logic [NUM_SLOTS-1:0] match
);
    // One comparator per slot.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign match[g] = slots[g].en &&
                          (((slots[g].pattern ^ rid) & ~slots[g].dc_mask) == '0);
    end
endmodule

// File: rtl/rid_lut_prio.sv
// Lowest-index-wins priority resolution over the match vector.
// Assumes bit 0 has the highest priority.
// Produces a one-hot grant and an any-hit flag.
module rid_lut_prio #(
    parameter int NUM_SLOTS = 32
) (
    input  logic [NUM_SLOTS-1:0] match,
    output logic [NUM_SLOTS-1:0] grant,
    output logic                 any
);
    // Isolate the lowest set bit of the match vector.
    always_comb begin
        grant = match & (~match + NUM_SLOTS'(1));
        any   = |match;
    end

    // At most one slot is granted.
    always_comb assert_one_grant_R6: assert ($onehot0(grant));

    // A grant is only given to a matching slot.
    always_comb assert_grant_matches_R6: assert ((grant & ~match) == '0);
endmodule

// File: rtl/rid_stream_lut.sv
// Top: requester-ID to stream-ID translation table.
// Register port writes/reads slots; lookup result is registered one clock.
// Assumes lookups compare against the table state before a same-cycle write.
module rid_stream_lut
    import rid_lut_pkg::*;
#(
    parameter int          NUM_SLOTS = 32,
    parameter logic [11:0] TBL_BASE  = 12'h800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_valid,
    input  logic [15:0] lk_rid,
    output logic        res_valid,
    output logic        res_hit,
    output logic [15:0] res_sid
);
    slot_t                slots [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] match;
    logic [NUM_SLOTS-1:0] grant;
    logic                 any;
    logic [NUM_SLOTS-1:0] en_vec;
    logic [SID_W-1:0]     sel_sid;

    rid_lut_regs #(.NUM_SLOTS(NUM_SLOTS), .TBL_BASE(TBL_BASE)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slots(slots)
    );

    rid_lut_match #(.NUM_SLOTS(NUM_SLOTS)) i_match (
        .slots(slots), .rid(lk_rid), .match(match)
    );

    rid_lut_prio #(.NUM_SLOTS(NUM_SLOTS)) i_prio (
        .match(match), .grant(grant), .any(any)
    );

    // OR together the stream IDs of granted slots; zero when none.
    always_comb begin
        sel_sid = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            en_vec[i] = slots[i].en;
            if (grant[i]) sel_sid = sel_sid | slots[i].sid;
        end
    end

    // Register the lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_sid   <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && any;
            res_sid   <= (lk_valid && any) ? sel_sid : '0;
        end
    end

    // No hit is reported without a lookup.
    assert_idle_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_hit);

    // A miss drives a zero stream ID.
    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> res_sid == '0);

    // A hit requires some slot to have been enabled at lookup time.
    assert_hit_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && en_vec == '0) |=> !res_hit);
endmodule

// File: tb/test_rid_stream_lut.sv
module test_rid_stream_lut;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_rid = '0;
    logic        res_valid;
    logic        res_hit;
    logic [15:0] res_sid;

    int checks = 0;
    int fails  = 0;

    // Vector format: {requester ID, expected hit, expected stream ID}
    localparam logic [32:0] VECS [8] = '{
        {16'h0100, 1'b1, 16'h0011},   // R6: slots 0 and 1 both match, 0 wins
        {16'h01AB, 1'b1, 16'h0022},   // R4: low byte don't-care in slot 1
        {16'h0200, 1'b0, 16'h0000},   // R7: nothing matches
        {16'h2000, 1'b0, 16'h0000},   // R5: slot 2 disabled
        {16'h3005, 1'b1, 16'h0044},   // R4: low three bits don't-care
        {16'h3008, 1'b0, 16'h0000},   // R4: bit 3 must compare
        {16'hABCD, 1'b1, 16'hBEEF},   // R2: last slot exact match
        {16'hABCC, 1'b0, 16'h0000}    // R4: all-zero mask demands full match
    };

    rid_stream_lut i_rid_stream_lut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_rid(lk_rid), .res_valid(res_valid), .res_hit(res_hit), .res_sid(res_sid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic look(input logic [15:0] rid, output logic v, output logic h, output logic [15:0] s);
        @(negedge clk);
        lk_valid = 1'b1; lk_rid = rid;
        @(negedge clk);
        lk_valid = 1'b0;
        v = res_valid; h = res_hit; s = res_sid;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic v, h;
        logic [15:0] s;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 res_valid", 32'(res_valid), 0);
        chk("R1 res_hit", 32'(res_hit), 0);
        chk("R1 res_sid", 32'(res_sid), 0);
        rd(12'h800, d); chk("R1 slot0 upper", d, 0);
        rd(12'h8FC, d); chk("R1 slot31 lower", d, 0);
        look(16'h0000, v, h, s); chk("R1 lookup on empty table", {h, s}, 0);

        // program table
        wr(12'h800, 32'h0100_0000); wr(12'h804, 32'h8000_0011);
        wr(12'h808, 32'h0100_00FF); wr(12'h80C, 32'h8000_0022);
        wr(12'h810, 32'h2000_0000); wr(12'h814, 32'h0000_0033);
        wr(12'h828, 32'h3000_0007); wr(12'h82C, 32'h8000_0044);
        wr(12'h8F8, 32'hABCD_0000); wr(12'h8FC, 32'h8000_BEEF);

        // R2, R3, R11 readback
        rd(12'h808, d); chk("R2 slot1 upper readback", d, 32'h0100_00FF);
        rd(12'h804, d); chk("R3 slot0 lower readback", d, 32'h8000_0011);
        wr(12'h81C, 32'h80FF_0077);
        rd(12'h81C, d); chk("R3 reserved bits read zero", d, 32'h8000_0077);

        // R10 outside the table
        wr(12'h900, 32'hFFFF_FFFF);
        rd(12'h900, d); chk("R10 write past table ignored", d, 0);
        rd(12'h7F8, d); chk("R10 below table reads zero", d, 0);
        look(16'hFFFF, v, h, s); chk("R10 stray write made no slot", {h, s}, 0);

        // vector walk (R4 R5 R6 R7)
        foreach (VECS[i]) begin
            look(VECS[i][32:17], v, h, s);
            chk($sformatf("R4/R5/R6/R7 vector %0d", i), {15'b0, h, s}, {15'b0, VECS[i][16:0]});
        end

        // R8 timing
        look(16'hABCD, v, h, s); chk("R8 res_valid after lookup", 32'(v), 1);
        @(negedge clk);
        chk("R8 idle cycle no valid", 32'(res_valid), 0);
        chk("R8 idle cycle no hit", 32'(res_hit), 0);

        // R9: enable slot 2 in the same cycle as a lookup for it
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h814; reg_wdata = 32'h8000_0033;
        lk_valid = 1'b1; lk_rid = 16'h2000;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R9 same-cycle lookup sees old table", {res_hit, res_sid}, 0);
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R9 next lookup sees new slot", {res_hit, res_sid}, {1'b1, 16'h0033});

        // R5/R6: disabling slot 0 hands 0x0100 to slot 1
        wr(12'h804, 32'h0000_0011);
        look(16'h0100, v, h, s); chk("R6 next slot wins after disable", {h, s}, {1'b1, 16'h0022});

        // R1: reset clears programmed slots
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look(16'hABCD, v, h, s); chk("R1 reset clears slots", {h, s}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule